// File: doc/BRIEF.md
# Loopback Path Selector

This block steers the transmit and receive streams of a multi-channel line interface between the system side and the line side. It supports five diagnostic routings: normal, digital loopback, analog loopback, remote loopback and dual loopback. Each line-side and system-side stream is modelled as a `DATA_W`-bit symbol with a clock strobe. `DATA_W` defaults to 2, which is one bit for each rail of a dual-rail signal.

The routing for each channel comes from one of two sources. In host mode it comes from three control bits: digital, analog and remote. In hardware mode it comes from a tri-level strap pin, encoded as two bits per channel. A separate all-ones request forces a mark-only pattern onto the line driver. That request is honoured only in the modes where the line driver still carries the system's own transmit data.

The resolved routing is registered once per channel. The selected streams are then registered at the output, so a routing change can never produce a glitch on any output.

Top module: `loopback_selector`

## Requirements
- R1: In normal mode, `lineTxData`/`lineTxStb` carry `txData`/`txStb`, and `sysRxData`/`sysRxStb` carry `rxLineData`/`rxLineStb`.
- R2: In digital loopback, `sysRxData`/`sysRxStb` carry the transmit stream. The transmit stream also still drives the line outputs, and the line input is ignored.
- R3: In analog loopback, the value driven onto the line returns on `sysRxData`/`sysRxStb`. This is the all-ones pattern when R8 forces it, and the transmit data otherwise. The line input is ignored.
- R4: In remote loopback, the recovered line stream drives both the line outputs and the system receive outputs, and the system transmit inputs are ignored.
- R5: In dual loopback, the transmit stream returns on the system receive outputs, and the recovered line stream goes back out on the line outputs.
- R6: In host mode, a channel's bits resolve in priority order. Digital and remote both set gives dual. Otherwise remote set gives remote, then analog set gives analog, then digital set gives digital. With none set, the channel is normal.
- R7: In hardware mode (`hostMode`=0), the channel's two pin bits select the mode and the host bits are ignored. Code 2'b00 (pin low) selects remote, code 2'b01 (pin high) selects analog, and codes 2'b10 and 2'b11 (pin open) select normal. Digital and dual cannot be reached this way.
- R8: When a channel's `allOnesReq` is 1 in normal, digital or analog mode, `lineTxData` is all ones with `lineTxStb`=`txStb`. In remote and dual mode, the request has no effect.
- R9: The routing settles at one clock edge and is applied from the following edge. Every output is registered with one cycle of latency. While `rstN` is low, every output is 0 and the routing is normal.
- R10: Channels are routed independently. Channel i uses bit i of each per-channel control and the data slice [i*DATA_W +: DATA_W].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive-path clock |
| rstN | input | 1 | Asynchronous active-low reset |
| hostMode | input | 1 | 1: use host bits; 0: use strap pins |
| hostDigital | input | NUM_CH | Per-channel digital loopback bit |
| hostAnalog | input | NUM_CH | Per-channel analog loopback bit |
| hostRemote | input | NUM_CH | Per-channel remote loopback bit |
| strapPin | input | 2*NUM_CH | Tri-level pin code, 2 bits per channel |
| allOnesReq | input | NUM_CH | Per-channel all-ones transmit request |
| txData | input | NUM_CH*DATA_W | System transmit symbols |
| txStb | input | NUM_CH | System transmit clock strobes |
| rxLineData | input | NUM_CH*DATA_W | Recovered line receive symbols |
| rxLineStb | input | NUM_CH | Recovered receive clock strobes |
| lineTxData | output | NUM_CH*DATA_W | Symbols to the line driver |
| lineTxStb | output | NUM_CH | Line driver clock strobes |
| sysRxData | output | NUM_CH*DATA_W | Symbols to the system receive side |
| sysRxStb | output | NUM_CH | System receive clock strobes |

## Verification
The assertions assume that every input is synchronous to `clk` and settles before the edge. They also assume that the routing inputs stay put for the edge that latches them and the edge that applies them. Under that assumption, a one-cycle comparison against the previous input value is exact. The stimulus changes all inputs a unit of time after an edge. It then holds each random routing and data pattern for two edges before sampling. Only the latency test changes the routing for a single edge, and it checks the old-routing cycle directly.

// File: rtl/lbsel_pkg.sv
package lbsel_pkg;

  typedef enum logic [2:0] {
    MODE_NORMAL  = 3'd0,
    MODE_DIGITAL = 3'd1,
    MODE_ANALOG  = 3'd2,
    MODE_REMOTE  = 3'd3,
    MODE_DUAL    = 3'd4
  } lbMode_e;

  typedef enum logic [1:0] {
    RX_FROM_LINE   = 2'd0,
    RX_FROM_TX     = 2'd1,
    RX_FROM_DRIVER = 2'd2
  } rxSrc_e;

  // Strobes from control to datapath, one set per channel
  typedef struct packed {
    logic   lineFromRecovered;
    rxSrc_e rxSrc;
    logic   onesOn;
  } pathSel_t;

  localparam logic [1:0] PIN_LOW  = 2'b00;
  localparam logic [1:0] PIN_HIGH = 2'b01;

  function automatic lbMode_e resolveHost(input logic dig, input logic ana, input logic rem);
    if (dig && rem)  return MODE_DUAL;
    else if (rem)    return MODE_REMOTE;
    else if (ana)    return MODE_ANALOG;
    else if (dig)    return MODE_DIGITAL;
    else             return MODE_NORMAL;
  endfunction

  function automatic lbMode_e resolvePin(input logic [1:0] code);
    if (code == PIN_LOW)       return MODE_REMOTE;
    else if (code == PIN_HIGH) return MODE_ANALOG;
    else                       return MODE_NORMAL;
  endfunction

  function automatic pathSel_t modeToSel(input lbMode_e mode, input logic ones);
    pathSel_t s;
    s.lineFromRecovered = 1'b0;
    s.rxSrc             = RX_FROM_LINE;
    s.onesOn            = 1'b0;
    case (mode)
      MODE_DIGITAL: begin s.rxSrc = RX_FROM_TX;     s.onesOn = ones; end
      MODE_ANALOG:  begin s.rxSrc = RX_FROM_DRIVER; s.onesOn = ones; end
      MODE_REMOTE:  begin s.lineFromRecovered = 1'b1; s.rxSrc = RX_FROM_LINE; end
      MODE_DUAL:    begin s.lineFromRecovered = 1'b1; s.rxSrc = RX_FROM_TX; end
      default:      begin s.onesOn = ones; end
    endcase
    return s;
  endfunction

endpackage

// File: rtl/lbsel_ctrl.sv
module lbsel_ctrl
  import lbsel_pkg::*;
#(
  parameter int NUM_CH = 4
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    hostMode,
  input  logic [NUM_CH-1:0]       hostDigital,
  input  logic [NUM_CH-1:0]       hostAnalog,
  input  logic [NUM_CH-1:0]       hostRemote,
  input  logic [2*NUM_CH-1:0]     strapPin,
  input  logic [NUM_CH-1:0]       allOnesReq,
  output pathSel_t [NUM_CH-1:0]   selQ
);

  localparam pathSel_t SEL_RESET = '{lineFromRecovered: 1'b0, rxSrc: RX_FROM_LINE, onesOn: 1'b0};

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    lbMode_e  modeNext;
    pathSel_t selNext;

    always_comb begin
      if (hostMode)
        modeNext = resolveHost(hostDigital[ch], hostAnalog[ch], hostRemote[ch]);
      else
        modeNext = resolvePin(strapPin[2*ch +: 2]);
      selNext = modeToSel(modeNext, allOnesReq[ch]);
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) selQ[ch] <= SEL_RESET;
      else       selQ[ch] <= selNext;
    end

    AST_HW_NO_TX_RETURN: assert property (@(posedge clk) disable iff (!rstN)
      !hostMode |=> selQ[ch].rxSrc != RX_FROM_TX); // R7

    AST_REMOTE_BIT_LOOPS_LINE: assert property (@(posedge clk) disable iff (!rstN)
      (hostMode && hostRemote[ch]) |=> selQ[ch].lineFromRecovered); // R6

    AST_ONES_NOT_ON_LOOPED_LINE: assert property (@(posedge clk) disable iff (!rstN)
      (hostMode && hostRemote[ch] && allOnesReq[ch]) |=> !selQ[ch].onesOn); // R8
  end

endmodule

// File: rtl/lbsel_datapath.sv
module lbsel_datapath
  import lbsel_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int DATA_W = 2
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  pathSel_t [NUM_CH-1:0]      selQ,
  input  logic [NUM_CH*DATA_W-1:0]   txData,
  input  logic [NUM_CH-1:0]          txStb,
  input  logic [NUM_CH*DATA_W-1:0]   rxLineData,
  input  logic [NUM_CH-1:0]          rxLineStb,
  output logic [NUM_CH*DATA_W-1:0]   lineTxData,
  output logic [NUM_CH-1:0]          lineTxStb,
  output logic [NUM_CH*DATA_W-1:0]   sysRxData,
  output logic [NUM_CH-1:0]          sysRxStb
);

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    localparam int LO = ch * DATA_W;

    logic [DATA_W-1:0] drvData, lineNext, rxNext;
    logic              lineStbNext, rxStbNext;

    always_comb begin
      drvData = selQ[ch].onesOn ? {DATA_W{1'b1}} : txData[LO +: DATA_W];
      if (selQ[ch].lineFromRecovered) begin
        lineNext    = rxLineData[LO +: DATA_W];
        lineStbNext = rxLineStb[ch];
      end else begin
        lineNext    = drvData;
        lineStbNext = txStb[ch];
      end
      case (selQ[ch].rxSrc)
        RX_FROM_TX: begin
          rxNext    = txData[LO +: DATA_W];
          rxStbNext = txStb[ch];
        end
        RX_FROM_DRIVER: begin
          rxNext    = drvData;
          rxStbNext = txStb[ch];
        end
        default: begin
          rxNext    = rxLineData[LO +: DATA_W];
          rxStbNext = rxLineStb[ch];
        end
      endcase
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        lineTxData[LO +: DATA_W] <= '0;
        lineTxStb[ch]            <= 1'b0;
        sysRxData[LO +: DATA_W]  <= '0;
        sysRxStb[ch]             <= 1'b0;
      end else begin
        lineTxData[LO +: DATA_W] <= lineNext;
        lineTxStb[ch]            <= lineStbNext;
        sysRxData[LO +: DATA_W]  <= rxNext;
        sysRxStb[ch]             <= rxStbNext;
      end
    end

    AST_RX_FOLLOWS_LINE: assert property (@(posedge clk) disable iff (!rstN)
      (selQ[ch].rxSrc == RX_FROM_LINE) |=> sysRxStb[ch] == $past(rxLineStb[ch])); // R1

    AST_LINE_RECOVERED: assert property (@(posedge clk) disable iff (!rstN)
      selQ[ch].lineFromRecovered |=> lineTxData[LO +: DATA_W] == $past(rxLineData[LO +: DATA_W])); // R4

    AST_DUAL_RETURN: assert property (@(posedge clk) disable iff (!rstN)
      (selQ[ch].lineFromRecovered && selQ[ch].rxSrc == RX_FROM_TX)
        |=> sysRxData[LO +: DATA_W] == $past(txData[LO +: DATA_W])); // R5

    AST_ONES_ON_LINE: assert property (@(posedge clk) disable iff (!rstN)
      (selQ[ch].onesOn && !selQ[ch].lineFromRecovered) |=> &lineTxData[LO +: DATA_W]); // R8
  end

endmodule

// File: rtl/loopback_selector.sv
module loopback_selector
  import lbsel_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int DATA_W = 2
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       hostMode,
  input  logic [NUM_CH-1:0]          hostDigital,
  input  logic [NUM_CH-1:0]          hostAnalog,
  input  logic [NUM_CH-1:0]          hostRemote,
  input  logic [2*NUM_CH-1:0]        strapPin,
  input  logic [NUM_CH-1:0]          allOnesReq,
  input  logic [NUM_CH*DATA_W-1:0]   txData,
  input  logic [NUM_CH-1:0]          txStb,
  input  logic [NUM_CH*DATA_W-1:0]   rxLineData,
  input  logic [NUM_CH-1:0]          rxLineStb,
  output logic [NUM_CH*DATA_W-1:0]   lineTxData,
  output logic [NUM_CH-1:0]          lineTxStb,
  output logic [NUM_CH*DATA_W-1:0]   sysRxData,
  output logic [NUM_CH-1:0]          sysRxStb
);

  pathSel_t [NUM_CH-1:0] selQ;

  lbsel_ctrl #(.NUM_CH(NUM_CH)) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .hostMode    (hostMode),
    .hostDigital (hostDigital),
    .hostAnalog  (hostAnalog),
    .hostRemote  (hostRemote),
    .strapPin    (strapPin),
    .allOnesReq  (allOnesReq),
    .selQ        (selQ)
  );

  lbsel_datapath #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .selQ       (selQ),
    .txData     (txData),
    .txStb      (txStb),
    .rxLineData (rxLineData),
    .rxLineStb  (rxLineStb),
    .lineTxData (lineTxData),
    .lineTxStb  (lineTxStb),
    .sysRxData  (sysRxData),
    .sysRxStb   (sysRxStb)
  );

endmodule

// File: tb/sim_loopback_selector.sv
`timescale 1ns/1ps
module sim_loopback_selector;
  localparam int NC = 4;
  localparam int DW = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic hostMode = 1'b1;
  logic [NC-1:0] hostDigital = '0, hostAnalog = '0, hostRemote = '0, allOnesReq = '0;
  logic [2*NC-1:0] strapPin = '1;
  logic [NC*DW-1:0] txData = '0, rxLineData = '0;
  logic [NC-1:0] txStb = '0, rxLineStb = '0;
  logic [NC*DW-1:0] lineTxData, sysRxData;
  logic [NC-1:0] lineTxStb, sysRxStb;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  loopback_selector #(.NUM_CH(NC), .DATA_W(DW)) u0 (
    .clk(clk), .rstN(rstN), .hostMode(hostMode), .hostDigital(hostDigital),
    .hostAnalog(hostAnalog), .hostRemote(hostRemote), .strapPin(strapPin),
    .allOnesReq(allOnesReq), .txData(txData), .txStb(txStb),
    .rxLineData(rxLineData), .rxLineStb(rxLineStb), .lineTxData(lineTxData),
    .lineTxStb(lineTxStb), .sysRxData(sysRxData), .sysRxStb(sysRxStb)
  );

  // 0 normal, 1 digital, 2 analog, 3 remote, 4 dual
  function automatic int expMode(int ch);
    if (hostMode) begin
      if (hostDigital[ch] && hostRemote[ch]) return 4;
      if (hostRemote[ch]) return 3;
      if (hostAnalog[ch]) return 2;
      if (hostDigital[ch]) return 1;
      return 0;
    end
    if (strapPin[2*ch +: 2] == 2'b00) return 3;
    if (strapPin[2*ch +: 2] == 2'b01) return 2;
    return 0;
  endfunction

  function automatic logic [DW:0] expLine(int ch);
    int m = expMode(ch);
    if (m >= 3) return {rxLineStb[ch], rxLineData[ch*DW +: DW]};
    if (allOnesReq[ch]) return {txStb[ch], {DW{1'b1}}};
    return {txStb[ch], txData[ch*DW +: DW]};
  endfunction

  function automatic logic [DW:0] expRx(int ch);
    int m = expMode(ch);
    if (m == 1 || m == 4) return {txStb[ch], txData[ch*DW +: DW]};
    if (m == 2) return expLine(ch);
    return {rxLineStb[ch], rxLineData[ch*DW +: DW]};
  endfunction

  function automatic string modeTag(int ch);
    case (expMode(ch))
      1: return "R2";
      2: return "R3";
      3: return "R4";
      4: return "R5";
      default: return "R1";
    endcase
  endfunction

  task automatic check(string tag, logic [DW:0] act, logic [DW:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic checkAll(string extra);
    for (int ch = 0; ch < NC; ch++) begin
      string t = (extra == "") ? modeTag(ch) : extra;
      check({t, " line"}, {lineTxStb[ch], lineTxData[ch*DW +: DW]}, expLine(ch));
      check({t, " rx"}, {sysRxStb[ch], sysRxData[ch*DW +: DW]}, expRx(ch));
    end
  endtask

  task automatic settle();
    @(posedge clk); @(posedge clk); #1;
  endtask

  task automatic randData();
    txData = $urandom; rxLineData = $urandom;
    txStb = $urandom; rxLineStb = $urandom;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : stim
    logic [DW:0] oldLine;
    void'($urandom(32'h5eed_1234));
    txData = '1; rxLineData = '1; txStb = '1; rxLineStb = '1;
    repeat (3) @(posedge clk);
    #1;
    // R9: reset state
    check("R9 reset line", {|lineTxStb, |lineTxData}, '0);
    check("R9 reset rx", {|sysRxStb, |sysRxData}, '0);
    rstN = 1'b1;

    // R6: directed host combinations, one channel per combination
    hostMode = 1'b1;
    hostDigital = 4'b0101; hostRemote = 4'b0111; hostAnalog = 4'b1110;
    randData(); settle(); checkAll("R6");
    hostDigital = 4'b1011; hostRemote = 4'b0000; hostAnalog = 4'b0011;
    randData(); settle(); checkAll("R6");

    // R7: pin codes, host bits set to dual but ignored
    hostMode = 1'b0;
    hostDigital = '1; hostRemote = '1; hostAnalog = '1;
    strapPin = 8'b11_10_01_00;
    randData(); settle(); checkAll("R7");

    // R8: all-ones across normal, digital, analog, remote, dual
    hostMode = 1'b1; allOnesReq = '1;
    hostDigital = 4'b0010; hostAnalog = 4'b0100; hostRemote = 4'b1000;
    randData(); settle(); checkAll("R8");
    hostDigital = 4'b1001; hostRemote = 4'b1001; hostAnalog = 4'b0000;
    randData(); settle(); checkAll("R8");
    allOnesReq = '0;

    // R9: routing applies one edge after it is latched
    hostDigital = '0; hostRemote = '0; hostAnalog = '0;
    randData(); settle();
    hostRemote = 4'b0001; txData = 8'h00; rxLineData = 8'hFF; txStb = '1; rxLineStb = '0;
    @(posedge clk); #1;
    oldLine = {txStb[0], txData[1:0]};
    check("R9 old routing", {lineTxStb[0], lineTxData[1:0]}, oldLine);
    @(posedge clk); #1;
    check("R9 new routing", {lineTxStb[0], lineTxData[1:0]}, {1'b0, 2'b11});

    // R10 and R1..R5: random mixes of per-channel routing
    for (int it = 0; it < 400; it++) begin
      hostMode = ($urandom % 4) != 0;
      hostDigital = $urandom; hostAnalog = $urandom; hostRemote = $urandom;
      strapPin = $urandom; allOnesReq = $urandom;
      randData();
      settle();
      checkAll("");
      if (it % 50 == 0) checkAll("R10");
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule